// File: doc/BRIEF.md
# MSI Directory Parent Controller

This block sits on the memory side of a two-level cache system and keeps, for every line address, the MSI state that each child cache is believed to hold, plus one flag per child showing that a downgrade sent to that child has not yet been answered. Children send two kinds of traffic upward. Upgrade requests ask for S or M on an address. Responses answer a downgrade or give back a line of their own accord, and they may carry write-back data. The controller answers on one outgoing port. It either sends a grant to the requester or sends a downgrade order to a child whose copy stands in the way.

Requests and responses arrive on separate input channels. A request that is blocked behind outstanding downgrades therefore stays at the head of its channel, while responses keep flowing past it, and the system cannot deadlock. The line data is held in a small internal array. That array is updated only by write-backs from a child recorded in M.

The state codes are I = 2'b00, S = 2'b01 and M = 2'b10. The outgoing message kind is 0 for a grant and 1 for a downgrade order.

Top module: `msi_dir_ctrl`

## Requirements
- R1: After reset, every child is recorded as I for every address, no wait flag is set, every data word is zero, and `out_valid` is low while no input is valid.
- R2: Two states conflict only in the pairs (M,M), (M,S) and (S,M). A request from child c for state y is granted when no other child's recorded state conflicts with y and c's wait flag is clear. The grant carries kind 0, child c, the request address and state y, and child c's recorded state then becomes y.
- R3: A grant carries the stored data word when the requester was recorded as I, and zero otherwise.
- R4: When the request cannot be granted, the controller sends a downgrade order (kind 1) to the lowest-numbered conflicting child whose wait flag is clear, and sets that flag. The target state is I for a request for M and S for a request for S.
- R5: No downgrade order goes to a child that is already being waited on. With all conflicting children waited on, `out_valid` and `req_ready` stay low.
- R6: A request from a child whose own wait flag is set is not granted.
- R7: A response from child c writes its data to the stored word only when c was recorded as M. It sets c's recorded state to the responded state and clears c's wait flag.
- R8: A response is consumed in the cycle it is valid. In that cycle no request is accepted and `out_valid` is low.
- R9: At most one child is recorded as M for any address.
- R10: While `out_valid` is high and `out_ready` is low, no request is accepted and the directory is not changed by the request channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upgrade request present |
| req_ready | output | 1 | Upgrade request accepted this cycle (granted) |
| req_child | input | CHILD_W | Requesting child |
| req_addr | input | ADDR_W | Requested line address |
| req_state | input | 2 | Requested state (S or M) |
| rsp_valid | input | 1 | Child response present (always consumed) |
| rsp_child | input | CHILD_W | Responding child |
| rsp_addr | input | ADDR_W | Responded line address |
| rsp_state | input | 2 | State the child has moved to |
| rsp_data | input | DATA_W | Write-back data |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Outgoing message taken |
| out_kind | output | 1 | 0 grant, 1 downgrade order |
| out_child | output | CHILD_W | Destination child |
| out_addr | output | ADDR_W | Line address |
| out_state | output | 2 | Granted state or downgrade target |
| out_data | output | DATA_W | Line data on a grant, else zero |

## Verification
The bench builds the block with its defaults: four children, sixteen addresses and 32-bit data. Four children are enough to place two sharers ahead of an M requester, so the order of downgrade orders and the stall on waited children can be seen. A fourth child is left free to send voluntary write-backs at an unrelated address in the same cycle as a request. The 32-bit data lets distinct write-back patterns show which responses reached memory and which were dropped.

// File: rtl/msi_dir_pkg.sv
package msi_dir_pkg;

   localparam logic [1:0] ST_I = 2'b00;
   localparam logic [1:0] ST_S = 2'b01;
   localparam logic [1:0] ST_M = 2'b10;

   localparam logic KIND_GRANT = 1'b0;
   localparam logic KIND_DOWN  = 1'b1;

   // true when a holder in state h may coexist with a new holder in state n
   function automatic logic states_coexist(input logic [1:0] h, input logic [1:0] n);
      logic clash;
      clash = (h == ST_M && n != ST_I) || (h == ST_S && n == ST_M);
      return !clash;
   endfunction

   // state a conflicting child must drop to for a request of state n
   function automatic logic [1:0] drop_target(input logic [1:0] n);
      return (n == ST_M) ? ST_I : ST_S;
   endfunction

endpackage

// File: rtl/msi_dir_store.sv
module msi_dir_store #(
   parameter int N_CHILD = 4,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   // request-side read row
   input  logic [ADDR_W-1:0]           row_addr,
   output logic [N_CHILD-1:0][1:0]     row_state,
   output logic [N_CHILD-1:0]          row_wait,
   output logic [DATA_W-1:0]           row_data,
   // response-side read of one entry
   input  logic [ADDR_W-1:0]           rsp_addr,
   input  logic [$clog2(N_CHILD)-1:0]  rsp_child,
   output logic [1:0]                  rsp_cur,
   // response write
   input  logic                        rsp_en,
   input  logic [1:0]                  rsp_state,
   input  logic                        mem_we,
   input  logic [DATA_W-1:0]           mem_wdata,
   // request-side writes (address = row_addr)
   input  logic                        gnt_en,
   input  logic [$clog2(N_CHILD)-1:0]  gnt_child,
   input  logic [1:0]                  gnt_state,
   input  logic                        mark_en,
   input  logic [$clog2(N_CHILD)-1:0]  mark_child
);
   import msi_dir_pkg::*;

   localparam int NUM_ADDR = 1 << ADDR_W;

   logic [N_CHILD-1:0][1:0] dir_q  [NUM_ADDR];
   logic [N_CHILD-1:0]      wait_q [NUM_ADDR];
   logic [DATA_W-1:0]       mem_q  [NUM_ADDR];

   assign row_state = dir_q[row_addr];
   assign row_wait  = wait_q[row_addr];
   assign row_data  = mem_q[row_addr];
   assign rsp_cur   = dir_q[rsp_addr][rsp_child];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < NUM_ADDR; a++) begin
            dir_q[a]  <= '0;
            wait_q[a] <= '0;
            mem_q[a]  <= '0;
         end
      end else if (rsp_en) begin
         dir_q[rsp_addr][rsp_child]  <= rsp_state;
         wait_q[rsp_addr][rsp_child] <= 1'b0;
         if (mem_we) mem_q[rsp_addr] <= mem_wdata;
      end else begin
         if (gnt_en)  dir_q[row_addr][gnt_child]   <= gnt_state;
         if (mark_en) wait_q[row_addr][mark_child] <= 1'b1;
      end
   end

   // R9: a single M holder per address
   for (genvar a = 0; a < NUM_ADDR; a++) begin : g_one_m
      logic [N_CHILD-1:0] m_vec;
      always_comb begin
         for (int i = 0; i < N_CHILD; i++) m_vec[i] = (dir_q[a][i] == ST_M);
      end
      a_r9_single_m: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(m_vec) <= 1);
   end

   // R7: a response leaves the entry in the responded state with its flag clear
   a_r7_rsp_clears_wait: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_en |=> (wait_q[$past(rsp_addr)][$past(rsp_child)] == 1'b0));
   a_r7_rsp_sets_state: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_en |=> (dir_q[$past(rsp_addr)][$past(rsp_child)] == $past(rsp_state)));

endmodule

// File: rtl/msi_dir_conflict.sv
module msi_dir_conflict #(
   parameter int N_CHILD = 4
) (
   input  logic [N_CHILD-1:0][1:0]     row_state,
   input  logic [N_CHILD-1:0]          row_wait,
   input  logic [$clog2(N_CHILD)-1:0]  req_child,
   input  logic [1:0]                  req_state,
   output logic [N_CHILD-1:0]          clash_vec,
   output logic [N_CHILD-1:0]          cand_vec
);
   import msi_dir_pkg::*;

   for (genvar i = 0; i < N_CHILD; i++) begin : g_child
      logic other;
      assign other        = (req_child != i[$clog2(N_CHILD)-1:0]);
      assign clash_vec[i] = other && !states_coexist(row_state[i], req_state);
      assign cand_vec[i]  = clash_vec[i] && !row_wait[i];
   end

endmodule

// File: rtl/msi_dir_pick.sv
module msi_dir_pick #(
   parameter int N_CHILD = 4
) (
   input  logic [N_CHILD-1:0]          vec,
   output logic                        found,
   output logic [$clog2(N_CHILD)-1:0]  idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N_CHILD - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = i[$clog2(N_CHILD)-1:0];
         end
      end
   end
endmodule

// File: rtl/msi_dir_ctrl.sv
module msi_dir_ctrl #(
   parameter int N_CHILD = 4,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32,
   localparam int CHILD_W = $clog2(N_CHILD)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [CHILD_W-1:0] req_child,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [1:0]         req_state,
   input  logic               rsp_valid,
   input  logic [CHILD_W-1:0] rsp_child,
   input  logic [ADDR_W-1:0]  rsp_addr,
   input  logic [1:0]         rsp_state,
   input  logic [DATA_W-1:0]  rsp_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic               out_kind,
   output logic [CHILD_W-1:0] out_child,
   output logic [ADDR_W-1:0]  out_addr,
   output logic [1:0]         out_state,
   output logic [DATA_W-1:0]  out_data
);
   import msi_dir_pkg::*;

   if (N_CHILD < 2) begin : g_bad_n
      $error("msi_dir_ctrl: N_CHILD must be at least 2");
   end
   if ((1 << CHILD_W) != N_CHILD) begin : g_bad_pow
      $error("msi_dir_ctrl: N_CHILD must be a power of two");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("msi_dir_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("msi_dir_ctrl: DATA_W must be positive");
   end

   logic [N_CHILD-1:0][1:0] row_state;
   logic [N_CHILD-1:0]      row_wait;
   logic [DATA_W-1:0]       row_data;
   logic [1:0]              rsp_cur;
   logic [N_CHILD-1:0]      clash_vec, cand_vec;
   logic                    cand_found;
   logic [CHILD_W-1:0]      cand_idx;
   logic                    req_act, can_grant, out_fire;

   msi_dir_conflict #(.N_CHILD(N_CHILD)) u_conf (
      .row_state (row_state),
      .row_wait  (row_wait),
      .req_child (req_child),
      .req_state (req_state),
      .clash_vec (clash_vec),
      .cand_vec  (cand_vec)
   );

   msi_dir_pick #(.N_CHILD(N_CHILD)) u_pick (
      .vec   (cand_vec),
      .found (cand_found),
      .idx   (cand_idx)
   );

   assign req_act   = req_valid && !rsp_valid;
   assign can_grant = (clash_vec == '0) && !row_wait[req_child];

   assign out_valid = req_act && (can_grant || cand_found);
   assign out_kind  = can_grant ? KIND_GRANT : KIND_DOWN;
   assign out_child = can_grant ? req_child : cand_idx;
   assign out_addr  = req_addr;
   assign out_state = can_grant ? req_state : drop_target(req_state);
   assign out_data  = (can_grant && row_state[req_child] == ST_I) ? row_data : '0;
   assign out_fire  = out_valid && out_ready;
   assign req_ready = out_fire && can_grant;

   msi_dir_store #(.N_CHILD(N_CHILD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .row_addr   (req_addr),
      .row_state  (row_state),
      .row_wait   (row_wait),
      .row_data   (row_data),
      .rsp_addr   (rsp_addr),
      .rsp_child  (rsp_child),
      .rsp_cur    (rsp_cur),
      .rsp_en     (rsp_valid),
      .rsp_state  (rsp_state),
      .mem_we     (rsp_valid && rsp_cur == ST_M),
      .mem_wdata  (rsp_data),
      .gnt_en     (req_ready),
      .gnt_child  (req_child),
      .gnt_state  (req_state),
      .mark_en    (out_fire && !can_grant),
      .mark_child (cand_idx)
   );

   // R8: responses take the cycle
   a_r8_rsp_first: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!out_valid && !req_ready));
   // R5: a downgrade never targets a child already waited on
   a_r5_no_repeat_down: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == KIND_DOWN) |-> !row_wait[out_child]);
   // R6: a waited requester is not granted
   a_r6_waited_held: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && row_wait[req_child]) |-> !req_ready);
   // R3: grants to a non-I holder carry no data
   a_r3_no_data_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == KIND_GRANT && row_state[req_child] != ST_I) |-> (out_data == '0));
   // R10: back-pressure holds the request
   a_r10_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !req_ready);

endmodule

// File: tb/sim_msi_dir_ctrl.sv
module sim_msi_dir_ctrl;
   localparam int NC = 4, AW = 4, DW = 32, CW = 2;
   localparam logic [1:0] I = 2'b00, S = 2'b01, M = 2'b10;
   localparam logic G = 1'b0, D = 1'b1;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_ready;
   logic [CW-1:0] req_child = '0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0] req_state = '0;
   logic rsp_valid = 0;
   logic [CW-1:0] rsp_child = '0;
   logic [AW-1:0] rsp_addr = '0;
   logic [1:0] rsp_state = '0;
   logic [DW-1:0] rsp_data = '0;
   logic out_valid, out_ready = 1, out_kind;
   logic [CW-1:0] out_child;
   logic [AW-1:0] out_addr;
   logic [1:0] out_state;
   logic [DW-1:0] out_data;

   int checks = 0, errors = 0, cyc = 0;
   logic [40:0] exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   msi_dir_ctrl #(.N_CHILD(NC), .ADDR_W(AW), .DATA_W(DW)) u0 (.*);

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic expect_msg(input logic k, input int c, input int a, input logic [1:0] s,
                             input logic [31:0] d, input string tag);
      exp_q.push_back({k, c[CW-1:0], a[AW-1:0], s, d});
      tag_q.push_back(tag);
   endtask

   // monitor: compare every fired message with the scoreboard front
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            chk(0, "unexpected message", {23'd0, out_kind, out_child, out_addr, out_state, out_data}, 64'd0);
         end else begin
            logic [40:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({out_kind, out_child, out_addr, out_state, out_data} == e, t,
                {23'd0, out_kind, out_child, out_addr, out_state, out_data}, {23'd0, e});
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic set_req(input int c, input int a, input logic [1:0] s);
      req_valid = 1; req_child = c[CW-1:0]; req_addr = a[AW-1:0]; req_state = s;
   endtask

   task automatic wait_accept();
      do @(negedge clk); while (!req_ready);
      tick();
      req_valid = 0;
   endtask

   task automatic send_resp(input int c, input int a, input logic [1:0] s, input logic [31:0] d);
      rsp_valid = 1; rsp_child = c[CW-1:0]; rsp_addr = a[AW-1:0]; rsp_state = s; rsp_data = d;
      @(negedge clk);
      chk(!out_valid && !req_ready, "R8 response blocks request channel",
          {62'd0, out_valid, req_ready}, 64'd0);
      tick();
      rsp_valid = 0;
   endtask

   task automatic check_stall(input string tag);
      @(negedge clk);
      chk(!out_valid && !req_ready, tag, {62'd0, out_valid, req_ready}, 64'd0);
   endtask

   initial begin
      repeat (3) tick();
      @(negedge clk);
      chk(!out_valid && !req_ready, "R1 idle during reset", {62'd0, out_valid, req_ready}, 64'd0);
      rst_n = 1;
      tick();
      check_stall("R1 idle after reset");

      // R1 R2 R3 R10: first reader gets zero data; back-pressure holds it
      expect_msg(G, 0, 3, S, 32'h0, "R1 R3 first grant from reset memory");
      out_ready = 0;
      set_req(0, 3, S);
      @(negedge clk);
      chk(out_valid && !req_ready, "R10 held under back-pressure", {62'd0, out_valid, req_ready}, 64'd2);
      tick();
      @(negedge clk);
      chk(out_valid && !req_ready, "R10 still held", {62'd0, out_valid, req_ready}, 64'd2);
      tick();
      out_ready = 1;
      wait_accept();

      // R2: S with S coexist
      expect_msg(G, 1, 3, S, 32'h0, "R2 second sharer granted");
      set_req(1, 3, S);
      wait_accept();

      // R4 R5 R7 R9: M request downgrades both sharers, lowest first
      expect_msg(D, 0, 3, I, 32'h0, "R4 downgrade child 0 to I");
      expect_msg(D, 1, 3, I, 32'h0, "R4 downgrade child 1 to I");
      set_req(2, 3, M);
      tick();
      tick();
      check_stall("R5 stall with all conflicts waited");
      send_resp(0, 3, I, 32'hDEAD_0000);
      check_stall("R5 stall with child 1 still waited");
      expect_msg(G, 2, 3, M, 32'h0, "R7 R9 M grant, S write-back not stored");
      send_resp(1, 3, I, 32'hBEEF_0000);
      wait_accept();

      // R4 R7 R3: S request forces M holder to S, its data reaches the reader
      expect_msg(D, 2, 3, S, 32'h0, "R4 downgrade M holder to S");
      set_req(0, 3, S);
      tick();
      expect_msg(G, 0, 3, S, 32'h1234_5678, "R7 R3 grant carries written-back data");
      send_resp(2, 3, S, 32'h1234_5678);
      wait_accept();

      // R8: request and response in the same cycle; R7 write-back from I dropped
      expect_msg(G, 1, 3, S, 32'h1234_5678, "R8 request served after response");
      set_req(1, 3, S);
      send_resp(3, 7, I, 32'h0000_0777);
      wait_accept();
      expect_msg(G, 3, 7, S, 32'h0, "R7 write-back from I not stored");
      set_req(3, 7, S);
      wait_accept();

      // R6: waited requester held until its own response
      expect_msg(G, 0, 5, M, 32'h0, "R2 M grant on idle address");
      set_req(0, 5, M);
      wait_accept();
      expect_msg(D, 0, 5, I, 32'h0, "R4 downgrade M holder for M request");
      set_req(1, 5, M);
      tick();
      req_valid = 0;
      set_req(0, 5, S);
      check_stall("R6 waited requester not granted");
      expect_msg(G, 0, 5, S, 32'h5555_AAAA, "R6 R3 R7 regrant after write-back");
      send_resp(0, 5, I, 32'h5555_AAAA);
      wait_accept();

      repeat (4) tick();
      chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 64'd0);
      check_stall("R1 idle at end");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule